// File: doc/BRIEF.md
# SPI Master Receive Sample-Delay Selector

This block sits between the serial data input of an SPI master and its receive shift register. At high serial clock rates the data returned by a slave arrives late, because it makes a round trip through the pads, the board and the slave's own output stage. The nominal sample edge can then catch the previous bit. This block moves the capture point to a programmable number of half-cycle steps after the nominal sample strobe. The captured bit and its valid strobe reach the shift register together, delayed by the same amount.

Timing is counted on a base clock running at twice the rate of the reference cycle, so one base clock period is one half-cycle step. Three control bits select the delay: a mode bit, a first delay bit and a second delay bit. Together they form a non-binary code. One code value selects plain sampling with no added delay. Six others select 0.5, 1, 1.5, 2, 2.5 or 3 reference cycles. Short delays are meant for serial clocks above roughly 24 MHz, and the longest settings for rates above about 60 MHz. The code pins are loaded into the block only while the surrounding controller reports that no burst is in progress.

Top module: `sdly_capture`

## Requirements
- R1: While reset is active and after it is released, `cap_valid_o` and `cap_bit_o` are 0. Until a code is loaded, the block behaves as for normal sampling (0 steps).
- R2: Code {mode,a,b} = {1,0,0} selects normal sampling. For a strobe seen at base clock edge T, `cap_bit_o` holds the value `miso_i` had at edge T, and `cap_valid_o` is 1 for exactly the one cycle after edge T.
- R3: The codes {0,0,0}, {0,1,0}, {1,1,0}, {1,0,1}, {0,0,1} and {0,1,1} move the capture edge to T+1, T+2, T+3, T+4, T+5 and T+6 base clock edges respectively. Each step is half a reference cycle. `cap_bit_o` holds `miso_i` as sampled at that edge.
- R4: The unlisted code {1,1,1} behaves exactly as normal sampling (0 steps).
- R5: Each strobe produces exactly one valid cycle. The valid is delayed by the same number of steps as the capture point, and no valid appears without a strobe.
- R6: The code pins are loaded only at an edge where `burst_idle_i` is 1. A change on them while `burst_idle_i` is 0 has no effect on the delay used.
- R7: Strobes on consecutive base clock edges each produce their own valid cycle, in order, at every delay setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock, one period per half-cycle step |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_idle_i | input | 1 | High between bursts; allows the delay code to be loaded |
| mode_sel_i | input | 1 | Sample-mode bit of the delay code (first code bit) |
| dly_a_i | input | 1 | First delay bit of the delay code (second code bit) |
| dly_b_i | input | 1 | Second delay bit of the delay code (third code bit) |
| sample_stb_i | input | 1 | Nominal sample strobe, one cycle per serial bit |
| miso_i | input | 1 | Serial data input from the slave |
| cap_bit_o | output | 1 | Captured data bit |
| cap_valid_o | output | 1 | One-cycle strobe marking `cap_bit_o` as new |

## Verification
The serial input changes to a fresh random value on every base clock edge, so a bit captured one edge early or late differs from the expected bit about half the time. Each of the eight code values is run as a separate burst with random sparse strobes, and this separates every delay setting from its neighbours. A burst with a strobe on every edge shows whether overlapping strobes in flight are each kept. A burst where the code pins change in the middle of the burst shows whether the loading gate holds. The first burst after reset runs without loading any code, which exposes the reset default.

// File: rtl/sdly_pkg.sv
package sdly_pkg;

   // Largest delay reachable by the code table, in half-cycle steps.
   localparam int unsigned SDLY_TABLE_STEPS = 6;

   typedef struct packed {
      logic mode;   // sample-mode bit
      logic dly_a;  // first delay bit
      logic dly_b;  // second delay bit
   } sdly_code_t;

   // Map the three-bit control code to a number of half-cycle steps.
   function automatic logic [2:0] sdly_steps(input sdly_code_t c);
      logic [2:0] steps;
      unique case ({c.mode, c.dly_a, c.dly_b})
         3'b000:  steps = 3'd1;
         3'b010:  steps = 3'd2;
         3'b110:  steps = 3'd3;
         3'b101:  steps = 3'd4;
         3'b001:  steps = 3'd5;
         3'b011:  steps = 3'd6;
         default: steps = 3'd0;  // 100 and 111: sample on the nominal edge
      endcase
      return steps;
   endfunction

endpackage

// File: rtl/sdly_code_latch.sv
module sdly_code_latch
   import sdly_pkg::*;
#(
   parameter int unsigned STEP_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  sdly_code_t        code_i,
   output logic [STEP_W-1:0] steps_o
);

   logic [STEP_W-1:0] steps_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         steps_q <= '0;
      end else if (load_i) begin
         steps_q <= STEP_W'(sdly_steps(code_i));
      end
   end

   assign steps_o = steps_q;

   AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(steps_q)); // R6

   AST_STEPS_IN_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      steps_q <= STEP_W'(SDLY_TABLE_STEPS)); // R3

endmodule

// File: rtl/sdly_strobe_line.sv
module sdly_strobe_line #(
   parameter int unsigned DEPTH = 6
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           stb_i,
   output logic [DEPTH:0] taps_o
);

   logic [DEPTH:0] taps;

   assign taps[0] = stb_i;

   for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            taps[g] <= 1'b0;
         end else begin
            taps[g] <= taps[g-1];
         end
      end
   end

   assign taps_o = taps;

endmodule

// File: rtl/sdly_capture.sv
module sdly_capture
   import sdly_pkg::*;
#(
   parameter int unsigned MAX_STEPS = 6
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic burst_idle_i,
   input  logic mode_sel_i,
   input  logic dly_a_i,
   input  logic dly_b_i,
   input  logic sample_stb_i,
   input  logic miso_i,
   output logic cap_bit_o,
   output logic cap_valid_o
);

   localparam int unsigned STEP_W = $clog2(MAX_STEPS + 1);

   if (MAX_STEPS < SDLY_TABLE_STEPS) begin : g_bad_depth
      $error("sdly_capture: MAX_STEPS must cover the code table");
   end

   sdly_code_t        code;
   logic [STEP_W-1:0] steps;
   logic [MAX_STEPS:0] taps;
   logic              fire;
   logic              bit_q;
   logic              vld_q;

   assign code = '{mode: mode_sel_i, dly_a: dly_a_i, dly_b: dly_b_i};

   sdly_code_latch #(.STEP_W(STEP_W)) i_code (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (burst_idle_i),
      .code_i  (code),
      .steps_o (steps)
   );

   sdly_strobe_line #(.DEPTH(MAX_STEPS)) i_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (sample_stb_i),
      .taps_o (taps)
   );

   // The tap chosen by the active step count marks the capture edge.
   assign fire = taps[steps];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bit_q <= 1'b0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= fire;
         if (fire) begin
            bit_q <= miso_i;
         end
      end
   end

   assign cap_bit_o   = bit_q;
   assign cap_valid_o = vld_q;

   AST_NORMAL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (steps == '0 && sample_stb_i) |=> cap_valid_o); // R2

   AST_NORMAL_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (steps == '0 && sample_stb_i) |=> (cap_bit_o == $past(miso_i))); // R2

   AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sample_stb_i && taps[MAX_STEPS:1] == '0) |=> !cap_valid_o); // R5

   AST_BIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_valid_o |=> (cap_valid_o || $stable(cap_bit_o))); // R5

endmodule

// File: tb/test_sdly_capture.sv
module test_sdly_capture;

   localparam int HIST = 8192;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic idle = 1'b0;
   logic c_mode = 1'b1;
   logic c_a = 1'b0;
   logic c_b = 1'b0;
   logic stb = 1'b0;
   logic miso = 1'b0;
   logic cap_bit;
   logic cap_vld;

   int errors = 0;
   int checks = 0;
   int tick = 0;
   int k_active = 0;
   bit done = 1'b0;

   bit stb_h [HIST];
   bit miso_h [HIST];
   int k_h [HIST];

   always #2 clk = ~clk;

   sdly_capture i_sdly_capture (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .burst_idle_i (idle),
      .mode_sel_i   (c_mode),
      .dly_a_i      (c_a),
      .dly_b_i      (c_b),
      .sample_stb_i (stb),
      .miso_i       (miso),
      .cap_bit_o    (cap_bit),
      .cap_valid_o  (cap_vld)
   );

   function automatic int exp_steps(input bit m, input bit a, input bit b);
      case ({m, a, b})
         3'b000:  return 1;
         3'b010:  return 2;
         3'b110:  return 3;
         3'b101:  return 4;
         3'b001:  return 5;
         3'b011:  return 6;
         default: return 0;
      endcase
   endfunction

   task automatic check(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s tick %0d: got %0d expected %0d", req, what, tick, got, exp);
      end
   endtask

   // Check outputs produced by edge tick-1, then drive inputs for edge tick.
   task automatic step(input string req, input bit s, input bit d, input bit ld,
                       input bit m, input bit a, input bit b);
      bit ev;
      bit eb;
      int e;
      @(negedge clk);
      if (tick > 0) begin
         e  = tick - 1;
         ev = 1'b0;
         eb = miso_h[e];
         for (int j = 0; j <= 6; j++) begin
            if (e - j >= 0 && stb_h[e-j] && k_h[e-j] == j) ev = 1'b1;
         end
         check(req, "valid", int'(cap_vld), int'(ev));
         if (ev) check(req, "bit", int'(cap_bit), int'(eb));
      end
      stb = s; miso = d; idle = ld; c_mode = m; c_a = a; c_b = b;
      stb_h[tick] = s; miso_h[tick] = d; k_h[tick] = k_active;
      if (ld) k_active = exp_steps(m, a, b);
      tick++;
   endtask

   // One burst: optional code load, random strobes, then a drain gap.
   task automatic burst(input string req, input bit load, input bit [2:0] code,
                        input int len, input int density, input bit glitch);
      bit [2:0] pins;
      if (load) step(req, 1'b0, 1'($urandom), 1'b1, code[2], code[1], code[0]);
      for (int i = 0; i < len; i++) begin
         pins = glitch ? 3'($urandom) : code;
         step(req, ($urandom % 100) < density, 1'($urandom), 1'b0, pins[2], pins[1], pins[0]);
      end
      for (int i = 0; i < 9; i++) step(req, 1'b0, 1'($urandom), 1'b0, code[2], code[1], code[0]);
   endtask

   initial begin
      void'($urandom(32'h5EED_0A17));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs cleared during reset
      check("R1", "valid in reset", int'(cap_vld), 0);
      check("R1", "bit in reset", int'(cap_bit), 0);
      rst_n = 1'b1;
      // R1: no code loaded yet, normal sampling expected
      burst("R1", 1'b0, 3'b100, 40, 35, 1'b0);
      burst("R2", 1'b1, 3'b100, 200, 35, 1'b0);
      burst("R3", 1'b1, 3'b000, 200, 35, 1'b0);
      burst("R3", 1'b1, 3'b010, 200, 35, 1'b0);
      burst("R3", 1'b1, 3'b110, 200, 35, 1'b0);
      burst("R3", 1'b1, 3'b101, 200, 35, 1'b0);
      burst("R3", 1'b1, 3'b001, 200, 35, 1'b0);
      burst("R3", 1'b1, 3'b011, 200, 35, 1'b0);
      burst("R4", 1'b1, 3'b111, 200, 35, 1'b0);
      // R5: sparse strobes, exactly one valid per strobe at long delay
      burst("R5", 1'b1, 3'b001, 150, 10, 1'b0);
      // R6: code pins wiggle while the burst runs; delay must not move
      burst("R6", 1'b1, 3'b011, 250, 40, 1'b1);
      burst("R6", 1'b1, 3'b000, 250, 40, 1'b1);
      // R7: strobe on every edge
      burst("R7", 1'b1, 3'b101, 60, 100, 1'b0);
      burst("R7", 1'b1, 3'b100, 60, 100, 1'b0);
      burst("R7", 1'b1, 3'b011, 60, 100, 1'b0);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule